// File: doc/BRIEF.md
# GPIO Port with Per-Line Interrupt Triggers

A sixteen-line general-purpose I/O port controlled through a flat word-wide register strobe: a byte address, a write enable, write data and combinational read data. Each line can be turned into an output by its direction bit. Its driven level is changed through a write-one-to-set register and a write-one-to-clear register, so software never needs a read-modify-write to touch one line. Pin inputs are resynchronised by two flops before software or the trigger logic sees them.

Every line has its own interrupt trigger. A line can be level-sensitive with a chosen polarity, or edge-sensitive on rising edges, falling edges or both. A trigger event sets a pending bit. That bit is reported only while the line's mask bit is 0 and its enable bit is 1. Software reads the gated pending word and clears bits by writing ones to a clear register. A single interrupt output is the OR of the gated pending bits.

The port has no state machine. Its behaviour is fixed by a register bank, a synchroniser, a per-line trigger decoder and a pending latch.

Top module: `gpio_trig_ctrl`

## Requirements
- R1: After reset the mask register (0x28) reads 0xFFFF, the enable register (0x2C) reads 0x0000, every other register reads 0, and `irq` is 0.
- R2: The direction register (0x00) drives `pin_oe` bit for bit: 1 makes the line an output and 0 makes it an input. It reads back what was written.
- R3: Writing the set register (0x18) makes every `pin_out` bit whose written bit is 1 go high. Writing the clear register (0x1C) makes every such bit go low. Bits written as 0 keep their value. The output word reads back at 0x20 and can also be written there directly.
- R4: The data-in register (0x14) returns the pin levels after two clock edges of synchronisation. A pin change is not visible after one edge and is visible after two.
- R5: When a line's select bit (0x04) is 1, the line is level-sensitive. Its polarity bit (0x08) picks active-high (1) or active-low (0), and the line is pending while its synchronised level matches the polarity.
- R6: When a line's select bit is 0, its rising enable (0x0C) triggers on 0-to-1 changes and its falling enable (0x10) triggers on 1-to-0 changes. With both enables set, the line triggers on either edge.
- R7: Pending bits latch whether or not the line is gated. The status register (0x30) returns pending AND NOT mask AND enable, so a line is reported only while its mask bit is 0 and its enable bit is 1.
- R8: Writing 1s to the clear register (0x34) clears the matching pending bits and leaves all other pending bits unchanged.
- R9: If a trigger event and a clear of the same line fall in the same cycle, the event wins and the bit stays pending. A still-active level line is therefore pending again after a clear.
- R10: `irq` is 1 exactly when the status word is non-zero.
- R11: The config registers read back what was written. The write-only offsets (0x18, 0x1C, 0x34) and unused offsets (such as 0x24) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 6 | Byte address of the register |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| pin_in | input | 16 | Raw pin levels |
| pin_out | output | 16 | Driven output levels |
| pin_oe | output | 16 | Output enable per line |
| irq | output | 1 | OR of all gated pending lines |

## Verification
The trigger logic is driven with three patterns. The first is a static level of each polarity, held across a clear, which shows level behaviour apart from a one-shot latch. The second is a pulse on lines with rising-only, falling-only and both-edge enables, which shows the three edge modes apart from each other. The third is a clear timed to land on the same edge as a fresh event, which separates clear-wins logic from event-wins logic. Gating is checked by raising an event while the line is masked and then unmasking it, which shows that the latch is separate from the gate. Partial clears show that the clear touches only the bits written as 1.

// File: rtl/gpio_trig_pkg.sv
package gpio_trig_pkg;
    localparam int NLINES = 16;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_DIR    = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_SEL    = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_POL    = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_RISE   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_FALL   = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_DIN    = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_OSET   = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_OCLR   = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_OUT    = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 6'h28;
    localparam logic [ADDR_W-1:0] OFS_EN     = 6'h2C;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 6'h30;
    localparam logic [ADDR_W-1:0] OFS_ICLR   = 6'h34;
endpackage

// File: rtl/gpio_trig_sync.sv
module gpio_trig_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_raw,
    output logic [W-1:0] level,
    output logic [W-1:0] level_prev
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level      = sync_q;
    assign level_prev = prev_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
    parameter int W = 16
) (
    input  logic [W-1:0] level,
    input  logic [W-1:0] level_prev,
    input  logic [W-1:0] lvl_sel,
    input  logic [W-1:0] lvl_pol,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    output logic [W-1:0] evt
);
    for (genvar i = 0; i < W; i++) begin : g_line
        logic went_up;
        logic went_down;
        logic lvl_hit;
        logic edge_hit;

        always_comb begin
            went_up  = level[i] & ~level_prev[i];
            went_down = ~level[i] & level_prev[i];
            lvl_hit  = (level[i] == lvl_pol[i]);
            edge_hit = (rise_en[i] & went_up) | (fall_en[i] & went_down);
            evt[i]   = lvl_sel[i] ? lvl_hit : edge_hit;
        end
    end
endmodule

// File: rtl/gpio_trig_pend.sv
module gpio_trig_pend #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] clr,
    output logic [W-1:0] pend
);
    logic [W-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr) | evt;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/gpio_trig_ctrl.sv
module gpio_trig_ctrl
    import gpio_trig_pkg::*;
#(
    parameter int NL = NLINES,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_we,
    input  logic [NL-1:0] reg_wdata,
    output logic [NL-1:0] reg_rdata,
    input  logic [NL-1:0] pin_in,
    output logic [NL-1:0] pin_out,
    output logic [NL-1:0] pin_oe,
    output logic          irq
);
    localparam logic [NL-1:0] ALL_ONES = {NL{1'b1}};

    logic [NL-1:0] dir_q, sel_q, pol_q, rise_q, fall_q, out_q, mask_q, en_q;
    logic [NL-1:0] lvl_w, lvl_prev_w, evt_w, pend_q, clr_w, stat_w;

    gpio_trig_sync #(.W(NL)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_raw    (pin_in),
        .level      (lvl_w),
        .level_prev (lvl_prev_w)
    );

    gpio_trig_detect #(.W(NL)) detect_i (
        .level      (lvl_w),
        .level_prev (lvl_prev_w),
        .lvl_sel    (sel_q),
        .lvl_pol    (pol_q),
        .rise_en    (rise_q),
        .fall_en    (fall_q),
        .evt        (evt_w)
    );

    assign clr_w = (reg_we && reg_addr == OFS_ICLR) ? reg_wdata : '0;

    gpio_trig_pend #(.W(NL)) pend_i (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt_w),
        .clr   (clr_w),
        .pend  (pend_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            sel_q  <= '0;
            pol_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            out_q  <= '0;
            mask_q <= ALL_ONES;
            en_q   <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                OFS_DIR:  dir_q  <= reg_wdata;
                OFS_SEL:  sel_q  <= reg_wdata;
                OFS_POL:  pol_q  <= reg_wdata;
                OFS_RISE: rise_q <= reg_wdata;
                OFS_FALL: fall_q <= reg_wdata;
                OFS_OSET: out_q  <= out_q | reg_wdata;
                OFS_OCLR: out_q  <= out_q & ~reg_wdata;
                OFS_OUT:  out_q  <= reg_wdata;
                OFS_MASK: mask_q <= reg_wdata;
                OFS_EN:   en_q   <= reg_wdata;
                default:  ;
            endcase
        end
    end

    assign stat_w = pend_q & ~mask_q & en_q;

    always_comb begin
        case (reg_addr)
            OFS_DIR:  reg_rdata = dir_q;
            OFS_SEL:  reg_rdata = sel_q;
            OFS_POL:  reg_rdata = pol_q;
            OFS_RISE: reg_rdata = rise_q;
            OFS_FALL: reg_rdata = fall_q;
            OFS_DIN:  reg_rdata = lvl_w;
            OFS_OUT:  reg_rdata = out_q;
            OFS_MASK: reg_rdata = mask_q;
            OFS_EN:   reg_rdata = en_q;
            OFS_STAT: reg_rdata = stat_w;
            default:  reg_rdata = '0;
        endcase
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign irq     = |stat_w;
endmodule

// File: rtl/gpio_trig_chk.sv
module gpio_trig_chk
    import gpio_trig_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] reg_addr,
    input logic          reg_we,
    input logic [W-1:0]  reg_wdata,
    input logic [W-1:0]  pin_out,
    input logic [W-1:0]  pin_oe,
    input logic          irq,
    input logic [W-1:0]  pend,
    input logic [W-1:0]  evt,
    input logic [W-1:0]  mask,
    input logic [W-1:0]  en
);
    assert_oe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_DIR) |=> (pin_oe == $past(reg_wdata)));

    assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_OSET) |=> ((pin_out & $past(reg_wdata)) == $past(reg_wdata)));

    assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_OCLR) |=> ((pin_out & $past(reg_wdata)) == '0));

    assert_gate_needed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((en & ~mask) != '0));

    assert_clear_takes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_ICLR) |=> ((pend & $past(reg_wdata) & ~$past(evt)) == '0));

    assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));
endmodule

bind gpio_trig_ctrl gpio_trig_chk #(.W(NL), .AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .pend      (pend_q),
    .evt       (evt_w),
    .mask      (mask_q),
    .en        (en_q)
);

// File: tb/gpio_trig_ctrl_tb_top.sv
module gpio_trig_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    gpio_trig_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic pins(logic [15:0] p);
        @(negedge clk);
        pin_in = p;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(6'h28, v); check("R1 mask", v, 16'hFFFF);
        rd(6'h2C, v); check("R1 enable", v, 16'h0000);
        rd(6'h00, v); check("R1 dir", v, 16'h0000);
        rd(6'h20, v); check("R1 out", v, 16'h0000);
        rd(6'h30, v); check("R1 status", v, 16'h0000);
        check("R1 irq", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_dir();
        logic [15:0] v;
        wr(6'h00, 16'hA5A5);
        check("R2 pin_oe", pin_oe, 16'hA5A5);
        rd(6'h00, v); check("R2 readback", v, 16'hA5A5);
    endtask

    task automatic t_out();
        logic [15:0] v;
        wr(6'h18, 16'hF00F); check("R3 set", pin_out, 16'hF00F);
        wr(6'h18, 16'h00F0); check("R3 set keeps", pin_out, 16'hF0FF);
        wr(6'h1C, 16'h0F0F); check("R3 clear", pin_out, 16'hF0F0);
        rd(6'h20, v); check("R3 readback", v, 16'hF0F0);
        wr(6'h20, 16'h1234); check("R3 direct", pin_out, 16'h1234);
    endtask

    task automatic t_datain();
        logic [15:0] v;
        reg_addr = 6'h14;
        @(negedge clk); reg_addr = 6'h14; pin_in = 16'h1234;
        @(posedge clk); #1 check("R4 one edge", reg_rdata, 16'h0000);
        @(posedge clk); #1 check("R4 two edges", reg_rdata, 16'h1234);
        pins(16'h0000);
        rd(6'h14, v); check("R4 back low", v, 16'h0000);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        wr(6'h0C, 16'h1357); rd(6'h0C, v); check("R11 rise rb", v, 16'h1357);
        wr(6'h10, 16'h2468); rd(6'h10, v); check("R11 fall rb", v, 16'h2468);
        rd(6'h18, v); check("R11 set reads 0", v, 16'h0000);
        rd(6'h24, v); check("R11 unused reads 0", v, 16'h0000);
        wr(6'h0C, 16'h0000); wr(6'h10, 16'h0000);
        wr(6'h34, 16'hFFFF);
    endtask

    task automatic t_level();
        logic [15:0] v;
        pins(16'h0002);
        wr(6'h28, 16'h0000); wr(6'h2C, 16'hFFFF);
        wr(6'h08, 16'h0001); wr(6'h04, 16'h0003);
        rd(6'h30, v); check("R5 idle", v, 16'h0000);
        pins(16'h0003);
        rd(6'h30, v); check("R5 active high", v, 16'h0001);
        check("R10 irq on", {15'd0, irq}, 16'h0001);
        wr(6'h34, 16'h0001);
        rd(6'h30, v); check("R9 level repends", v, 16'h0001);
        pins(16'h0000);
        wr(6'h34, 16'h0001);
        rd(6'h30, v); check("R5 active low", v, 16'h0002);
        pins(16'h0002);
        wr(6'h34, 16'hFFFF);
        rd(6'h30, v); check("R8 level cleared", v, 16'h0000);
        check("R10 irq off", {15'd0, irq}, 16'h0000);
        wr(6'h04, 16'h0000);
        pins(16'h0000);
        wr(6'h34, 16'hFFFF);
    endtask

    task automatic t_edge();
        logic [15:0] v;
        wr(6'h0C, 16'h00D1); wr(6'h10, 16'h0060);
        pins(16'h0070);
        rd(6'h30, v); check("R6 rising", v, 16'h0050);
        wr(6'h34, 16'hFFFF);
        pins(16'h0000);
        rd(6'h30, v); check("R6 falling", v, 16'h0060);
        wr(6'h34, 16'hFFFF);
        rd(6'h30, v); check("R8 all cleared", v, 16'h0000);
    endtask

    task automatic t_partial();
        logic [15:0] v;
        pins(16'h0050);
        wr(6'h34, 16'h0010);
        rd(6'h30, v); check("R8 partial clear", v, 16'h0040);
        check("R10 irq remains", {15'd0, irq}, 16'h0001);
        wr(6'h34, 16'h0040);
        check("R10 irq drops", {15'd0, irq}, 16'h0000);
        pins(16'h0000);
        wr(6'h34, 16'hFFFF);
    endtask

    task automatic t_gate();
        logic [15:0] v;
        wr(6'h28, 16'h0080);
        pins(16'h0080);
        rd(6'h30, v); check("R7 masked", v, 16'h0000);
        check("R7 masked irq", {15'd0, irq}, 16'h0000);
        wr(6'h28, 16'h0000);
        rd(6'h30, v); check("R7 unmasked latched", v, 16'h0080);
        wr(6'h2C, 16'hFF7F);
        rd(6'h30, v); check("R7 disabled", v, 16'h0000);
        check("R7 disabled irq", {15'd0, irq}, 16'h0000);
        wr(6'h2C, 16'hFFFF);
        pins(16'h0000);
        wr(6'h34, 16'hFFFF);
    endtask

    task automatic t_race();
        logic [15:0] v;
        pins(16'h0001);
        pins(16'h0000);
        rd(6'h30, v); check("R6 line0 pending", v, 16'h0001);
        @(negedge clk); pin_in = 16'h0001;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk); reg_addr = 6'h34; reg_we = 1'b1; reg_wdata = 16'h0001;
        @(negedge clk); reg_we = 1'b0;
        rd(6'h30, v); check("R9 event beats clear", v, 16'h0001);
        wr(6'h34, 16'h0001);
        rd(6'h30, v); check("R8 clear after race", v, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dir();
        t_out();
        t_datain();
        t_regs();
        t_level();
        t_edge();
        t_partial();
        t_gate();
        t_race();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule